// File: doc/BRIEF.md
# Limit-Cycle Auto-Tuning Sequencer

This block steps a digitally controlled converter loop through one retuning pass. When the loop reports a disturbance, the sequencer switches the compensator to a slow gain setting that is stable in every operating condition. Once the loop reports that regulation has returned, the sequencer coarsens the pulse-width modulator from 8-bit to 4-bit steps. This provokes a small self-oscillation of the output. An external measurement unit reports the peak-to-peak swing and the period of that oscillation.

The sequencer quantizes the swing and the period into bins. The pair of bins addresses three on-chip tables of 30 ten-bit words, one table for each of the proportional, integral and derivative terms. The three words are handed to the compensator in a single strobe cycle. The modulator then returns to fine resolution and the slow gain is released.

If the measurement reports that no oscillation exists, the sequencer asks for a small reference step to start one. If no usable measurement arrives within a bounded window, it falls back to the slow-gain state and waits for regulation again.

Top module: `lc_autotune_seq`

## Requirements
- R1: After reset the block is at rest: `res_low_o`, `reduced_gain_o`, `ref_nudge_o` and `coef_load_o` are 0, `coef_idx_o` is 0 and the coefficient outputs show table word 0.
- R2: `unstable_i` high at a clock edge puts the block in the recovery state from any state. In the recovery state `reduced_gain_o` is 1 and `res_low_o` is 0 (fine 8-bit modulation) from the next cycle on. `unstable_i` takes priority over `regulated_i`.
- R3: In the recovery state, `regulated_i` high with `unstable_i` low moves the block to extraction. There `res_low_o` is 1 (coarse 4-bit modulation) and `reduced_gain_o` stays 1.
- R4: The table index is computed as follows. The amplitude bin is min(floor(p2p/8), 4) and the period bin is min(floor(period/16), 5). The index is amplitude bin × 6 + period bin, in the range 0..29.
- R5: In extraction, `meas_valid_i` high with `meas_noosc_i` low latches the index. In the next cycle `coef_load_o` is 1 for exactly one cycle and presents all three words. In the cycle after that, `res_low_o` and `reduced_gain_o` are both 0.
- R6: For index k, the table words are P = (64 + 19k) mod 1024, I = (12 + 31k) mod 1024 and D = (900 − 27k) mod 1024.
- R7: In extraction, `meas_valid_i` high with `meas_noosc_i` high raises `ref_nudge_o` for one cycle in the next cycle. The block stays in extraction.
- R8: Extraction lasts at most `TMO_CYCLES` cycles. If no oscillating measurement is accepted in that time, the block returns to recovery, with `res_low_o` at 0 and `reduced_gain_o` at 1.
- R9: `meas_valid_i` outside extraction and `regulated_i` outside recovery have no effect on any output.
- R10: In extraction, `unstable_i` overrides a simultaneous valid measurement: no load strobe follows and the block returns to recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| unstable_i | input | 1 | Disturbance or instability flag |
| regulated_i | input | 1 | Regulation regained indication |
| meas_valid_i | input | 1 | Measurement result valid |
| meas_noosc_i | input | 1 | Measurement saw a zero period (no oscillation) |
| meas_p2p_i | input | AMP_W | Measured peak-to-peak error swing |
| meas_period_i | input | PER_W | Measured oscillation period in switching cycles |
| res_low_o | output | 1 | 1 = coarse 4-bit modulator, 0 = fine 8-bit |
| reduced_gain_o | output | 1 | Select the slow, always-stable compensator gain |
| ref_nudge_o | output | 1 | One-cycle request for a small reference step |
| coef_load_o | output | 1 | One-cycle coefficient load strobe |
| coef_idx_o | output | IDX_W | Table index behind the presented coefficients |
| coef_p_o | output | COEF_W | Proportional coefficient |
| coef_i_o | output | COEF_W | Integral coefficient |
| coef_d_o | output | COEF_W | Derivative coefficient |

## Verification
The assertions assume that every input holds a known value from the first edge after reset. They also assume the measurement fields are read only in a cycle where `meas_valid_i` is high. No assertion assumes any spacing between measurements, so back-to-back zero-period reports may produce back-to-back nudge pulses. The stimulus drives every input between clock edges and never leaves one unknown. The random phase mixes rare disturbances with frequent measurements, so timeouts, nudges and loads all occur next to one another.

// File: rtl/lcat_pkg.sv
package lcat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RECOVER = 2'd1,
    ST_EXTRACT = 2'd2,
    ST_LOAD    = 2'd3
  } lcat_state_e;

  localparam int unsigned N_TERMS = 3;

endpackage

// File: rtl/lcat_binner.sv
module lcat_binner #(
  parameter int unsigned AMP_W     = 8,
  parameter int unsigned PER_W     = 12,
  parameter int unsigned AMP_BINS  = 5,
  parameter int unsigned PER_BINS  = 6,
  parameter int unsigned AMP_SHIFT = 3,
  parameter int unsigned PER_SHIFT = 4,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [AMP_W-1:0] p2p_i,
  input  logic [PER_W-1:0] period_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [31:0] amp_bin;
  logic [31:0] per_bin;

  // amplitude bin: coarse shift, saturated at the last bin
  always_comb begin
    amp_bin = 32'(p2p_i >> AMP_SHIFT);
    if (amp_bin > AMP_BINS - 1) begin
      amp_bin = AMP_BINS - 1;
    end
  end

  // period bin: coarse shift, saturated at the last bin
  always_comb begin
    per_bin = 32'(period_i >> PER_SHIFT);
    if (per_bin > PER_BINS - 1) begin
      per_bin = PER_BINS - 1;
    end
  end

  assign idx_o = IDX_W'(amp_bin * PER_BINS + per_bin);

endmodule

// File: rtl/lcat_coef_rom.sv
module lcat_coef_rom #(
  parameter int unsigned DEPTH  = 30,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned COEF_W = 10,
  parameter int unsigned BASE   = 0,
  parameter int unsigned STEP   = 1
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [COEF_W-1:0] coef_o
);

  localparam int unsigned MODULUS = 1 << COEF_W;

  logic [COEF_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_word
    assign tbl[k] = COEF_W'((BASE + STEP * k) % MODULUS);
  end

  always_comb begin
    if (32'(idx_i) < DEPTH) begin
      coef_o = tbl[idx_i];
    end else begin
      coef_o = '0;
    end
  end

endmodule

// File: rtl/lcat_timeout.sv
module lcat_timeout #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);

  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expire_o = run_i && (cnt_q == CW'(LIMIT - 1));
  assign cnt_en   = run_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || expire_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // each extraction window starts counting from zero
  assert_window_starts_clean_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(run_i) |-> (cnt_q == '0));

  // the window never runs past its limit
  assert_window_bounded_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    run_i |-> (32'(cnt_q) < LIMIT));

endmodule

// File: rtl/lc_autotune_seq.sv
module lc_autotune_seq #(
  parameter int unsigned AMP_W      = 8,
  parameter int unsigned PER_W      = 12,
  parameter int unsigned AMP_BINS   = 5,
  parameter int unsigned PER_BINS   = 6,
  parameter int unsigned AMP_SHIFT  = 3,
  parameter int unsigned PER_SHIFT  = 4,
  parameter int unsigned COEF_W     = 10,
  parameter int unsigned TMO_CYCLES = 1000,
  localparam int unsigned DEPTH     = AMP_BINS * PER_BINS,
  localparam int unsigned IDX_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unstable_i,
  input  logic              regulated_i,
  input  logic              meas_valid_i,
  input  logic              meas_noosc_i,
  input  logic [AMP_W-1:0]  meas_p2p_i,
  input  logic [PER_W-1:0]  meas_period_i,
  output logic              res_low_o,
  output logic              reduced_gain_o,
  output logic              ref_nudge_o,
  output logic              coef_load_o,
  output logic [IDX_W-1:0]  coef_idx_o,
  output logic [COEF_W-1:0] coef_p_o,
  output logic [COEF_W-1:0] coef_i_o,
  output logic [COEF_W-1:0] coef_d_o
);

  import lcat_pkg::*;

  localparam int unsigned TERM_BASE [N_TERMS] = '{64, 12, 900};
  localparam int unsigned TERM_STEP [N_TERMS] = '{19, 31, (1 << COEF_W) - 27};

  // ---------------- reset release synchronizer ----------------
  logic rst_s1_q;
  logic rst_s2_q;
  logic rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign rst_ni = rst_s2_q;

  // ---------------- state and datapath registers ----------------
  lcat_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             nudge_q, nudge_d;
  logic             idx_en;
  logic             in_extract;
  logic             meas_osc;
  logic             meas_flat;
  logic             tmo_expire;
  logic [IDX_W-1:0] bin_idx;
  logic [COEF_W-1:0] coef_w [N_TERMS];

  assign in_extract = (state_q == ST_EXTRACT);
  assign meas_osc   = meas_valid_i && !meas_noosc_i;
  assign meas_flat  = meas_valid_i &&  meas_noosc_i;

  lcat_binner #(
    .AMP_W     (AMP_W),
    .PER_W     (PER_W),
    .AMP_BINS  (AMP_BINS),
    .PER_BINS  (PER_BINS),
    .AMP_SHIFT (AMP_SHIFT),
    .PER_SHIFT (PER_SHIFT),
    .IDX_W     (IDX_W)
  ) binner_i (
    .p2p_i    (meas_p2p_i),
    .period_i (meas_period_i),
    .idx_o    (bin_idx)
  );

  lcat_timeout #(
    .LIMIT (TMO_CYCLES)
  ) timeout_i (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .run_i    (in_extract),
    .expire_o (tmo_expire)
  );

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    lcat_coef_rom #(
      .DEPTH  (DEPTH),
      .IDX_W  (IDX_W),
      .COEF_W (COEF_W),
      .BASE   (TERM_BASE[t]),
      .STEP   (TERM_STEP[t])
    ) rom_i (
      .idx_i  (idx_q),
      .coef_o (coef_w[t])
    );
  end

  // ---------------- next-state logic ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (unstable_i) state_d = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (!unstable_i && regulated_i) state_d = ST_EXTRACT;
      end
      ST_EXTRACT: begin
        if (unstable_i)      state_d = ST_RECOVER;
        else if (meas_osc)   state_d = ST_LOAD;
        else if (tmo_expire) state_d = ST_RECOVER;
      end
      ST_LOAD: begin
        if (unstable_i) state_d = ST_RECOVER;
        else            state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign idx_en  = in_extract && !unstable_i && meas_osc;
  assign idx_d   = bin_idx;
  assign nudge_d = in_extract && !unstable_i && meas_flat;

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      nudge_q <= 1'b0;
    end else begin
      state_q <= state_d;
      nudge_q <= nudge_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  // ---------------- outputs ----------------
  assign res_low_o      = (state_q == ST_EXTRACT) || (state_q == ST_LOAD);
  assign reduced_gain_o = (state_q != ST_IDLE);
  assign coef_load_o    = (state_q == ST_LOAD);
  assign ref_nudge_o    = nudge_q;
  assign coef_idx_o     = idx_q;
  assign coef_p_o       = coef_w[0];
  assign coef_i_o       = coef_w[1];
  assign coef_d_o       = coef_w[2];

  // ---------------- assertions ----------------
  assert_unstable_gives_slow_gain_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    unstable_i |=> (reduced_gain_o && !res_low_o));

  assert_coarse_only_with_slow_gain_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    res_low_o |-> reduced_gain_o);

  assert_index_in_table_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    32'(coef_idx_o) < DEPTH);

  assert_load_is_single_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    coef_load_o |=> !coef_load_o);

  assert_load_follows_extract_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    coef_load_o |-> $past(res_low_o));

  assert_load_ends_tuning_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (coef_load_o && !unstable_i) |=> (!res_low_o && !reduced_gain_o));

  assert_nudge_from_extract_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    ref_nudge_o |-> $past(res_low_o && !coef_load_o));

  assert_unstable_blocks_load_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (unstable_i && res_low_o && !coef_load_o) |=> !coef_load_o);

endmodule

// File: tb/lc_autotune_seq_tb_top.sv
module lc_autotune_seq_tb_top;

  localparam int TMO = 64;

  logic        clk;
  logic        rst_n;
  logic        unstable;
  logic        regulated;
  logic        mvalid;
  logic        mnoosc;
  logic [7:0]  mp2p;
  logic [11:0] mper;
  logic        res_low;
  logic        slow_gain;
  logic        nudge;
  logic        load;
  logic [4:0]  idx;
  logic [9:0]  cp;
  logic [9:0]  ci;
  logic [9:0]  cd;

  int checks   = 0;
  int failures = 0;
  bit cmp_en   = 0;

  lc_autotune_seq #(.TMO_CYCLES(TMO)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .unstable_i     (unstable),
    .regulated_i    (regulated),
    .meas_valid_i   (mvalid),
    .meas_noosc_i   (mnoosc),
    .meas_p2p_i     (mp2p),
    .meas_period_i  (mper),
    .res_low_o      (res_low),
    .reduced_gain_o (slow_gain),
    .ref_nudge_o    (nudge),
    .coef_load_o    (load),
    .coef_idx_o     (idx),
    .coef_p_o       (cp),
    .coef_i_o       (ci),
    .coef_d_o       (cd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- expected table contents (R6) ----------------
  function automatic int exp_p(int k); return (64 + 19 * k) % 1024; endfunction
  function automatic int exp_i(int k); return (12 + 31 * k) % 1024; endfunction
  function automatic int exp_d(int k); return (900 - 27 * k + 1024) % 1024; endfunction

  function automatic int exp_idx(int a, int p);
    int ab;
    int pb;
    ab = a / 8;
    if (ab > 4) ab = 4;
    pb = p / 16;
    if (pb > 5) pb = 5;
    return ab * 6 + pb;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // modes: 0 rest, 1 recovery, 2 extraction, 3 loading
  int m_mode;
  int m_wait;
  int m_idx;
  bit m_nudge;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode  <= 0;
      m_wait  <= 0;
      m_idx   <= 0;
      m_nudge <= 0;
    end else begin
      int nm;
      nm = m_mode;
      m_nudge <= (m_mode == 2) && !unstable && mvalid && mnoosc;
      if (unstable) begin
        nm = 1;
      end else if (m_mode == 0) begin
        nm = 0;
      end else if (m_mode == 1) begin
        if (regulated) nm = 2;
      end else if (m_mode == 2) begin
        if (mvalid && !mnoosc) begin
          nm = 3;
          m_idx <= exp_idx(int'(mp2p), int'(mper));
        end else if (m_wait + 1 >= TMO) begin
          nm = 1;
        end
      end else begin
        nm = 0;
      end
      if (m_mode == 2 && nm == 2) m_wait <= m_wait + 1;
      else                        m_wait <= 0;
      m_mode <= nm;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2 model slow gain",  32'(slow_gain), 32'(m_mode != 0));
      chk("R3 model coarse res", 32'(res_low),   32'(m_mode >= 2));
      chk("R5 model load",       32'(load),      32'(m_mode == 3));
      chk("R7 model nudge",      32'(nudge),     32'(m_nudge));
      chk("R4 model index",      32'(idx),       32'(m_idx));
      chk("R6 model coef P",     32'(cp),        32'(exp_p(m_idx)));
      chk("R6 model coef I",     32'(ci),        32'(exp_i(m_idx)));
      chk("R6 model coef D",     32'(cd),        32'(exp_d(m_idx)));
    end
  end

  // ---------------- stimulus helpers ----------------
  // called at negedge+2; sets inputs and returns at the next negedge+2
  task automatic tick(input bit u, input bit r, input bit v, input bit n,
                      input int a, input int p);
    unstable  = u;
    regulated = r;
    mvalid    = v;
    mnoosc    = n;
    mp2p      = 8'(a);
    mper      = 12'(p);
    @(negedge clk);
    #2;
  endtask

  task automatic idle();
    tick(0, 0, 0, 0, 0, 0);
  endtask

  task automatic enter_extract();
    tick(1, 0, 0, 0, 0, 0);
    tick(0, 1, 0, 0, 0, 0);
  endtask

  task automatic check_load(input string tag, input int a, input int p);
    int k;
    k = exp_idx(a, p);
    tick(0, 0, 1, 0, a, p);
    chk({tag, " R5 load strobe"}, 32'(load), 32'd1);
    chk({tag, " R4 index"},       32'(idx),  32'(k));
    chk({tag, " R6 P word"},      32'(cp),   32'(exp_p(k)));
    chk({tag, " R6 I word"},      32'(ci),   32'(exp_i(k)));
    chk({tag, " R6 D word"},      32'(cd),   32'(exp_d(k)));
    idle();
    chk({tag, " R5 strobe drops"}, 32'(load),      32'd0);
    chk({tag, " R5 fine res"},     32'(res_low),   32'd0);
    chk({tag, " R5 gain restored"},32'(slow_gain), 32'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int n;
    rst_n     = 1'b0;
    unstable  = 0;
    regulated = 0;
    mvalid    = 0;
    mnoosc    = 0;
    mp2p      = '0;
    mper      = '0;
    repeat (3) @(negedge clk);
    #2;
    rst_n = 1'b1;
    repeat (4) idle();
    cmp_en = 1;

    // R1 reset state
    chk("R1 res_low",   32'(res_low),   32'd0);
    chk("R1 slow gain", 32'(slow_gain), 32'd0);
    chk("R1 nudge",     32'(nudge),     32'd0);
    chk("R1 load",      32'(load),      32'd0);
    chk("R1 index",     32'(idx),       32'd0);
    chk("R1 P word 0",  32'(cp),        32'd64);

    // R9 measurement and regulation ignored at rest
    tick(0, 1, 1, 0, 100, 100);
    chk("R9 rest load",   32'(load),      32'd0);
    chk("R9 rest gain",   32'(slow_gain), 32'd0);
    chk("R9 rest coarse", 32'(res_low),   32'd0);
    chk("R9 rest index",  32'(idx),       32'd0);

    // R2 disturbance
    tick(1, 0, 0, 0, 0, 0);
    chk("R2 slow gain", 32'(slow_gain), 32'd1);
    chk("R2 fine res",  32'(res_low),   32'd0);

    // R9 measurement ignored in recovery
    tick(0, 0, 1, 0, 40, 40);
    chk("R9 recovery load",  32'(load),    32'd0);
    chk("R9 recovery index", 32'(idx),     32'd0);
    chk("R9 recovery res",   32'(res_low), 32'd0);

    // R2 priority over regulation
    tick(1, 1, 0, 0, 0, 0);
    chk("R2 priority res", 32'(res_low), 32'd0);

    // R3 regulation regained
    tick(0, 1, 0, 0, 0, 0);
    chk("R3 coarse res", 32'(res_low),   32'd1);
    chk("R3 slow gain",  32'(slow_gain), 32'd1);

    // R7 zero-period measurement
    tick(0, 0, 1, 1, 0, 0);
    chk("R7 nudge pulse", 32'(nudge),   32'd1);
    chk("R7 stays coarse",32'(res_low), 32'd1);
    chk("R7 no load",     32'(load),    32'd0);
    idle();
    chk("R7 nudge single", 32'(nudge), 32'd0);

    // R4 R5 R6 mid-table index
    check_load("mid", 20, 50);

    // R4 saturation in both bins
    enter_extract();
    check_load("sat", 255, 4095);

    // R4 lowest bins
    enter_extract();
    check_load("low", 7, 15);

    // R10 disturbance beats a valid measurement
    enter_extract();
    tick(1, 0, 1, 0, 20, 50);
    chk("R10 no load",   32'(load),      32'd0);
    chk("R10 fine res",  32'(res_low),   32'd0);
    chk("R10 slow gain", 32'(slow_gain), 32'd1);
    chk("R10 index kept",32'(idx),       32'd0);

    // R8 timeout window
    tick(0, 1, 0, 0, 0, 0);
    n = 0;
    while (res_low && n < 10000) begin
      n++;
      idle();
    end
    chk("R8 window length", 32'(n),         32'(TMO));
    chk("R8 back to slow",  32'(slow_gain), 32'd1);

    // R2 disturbance during the load cycle
    enter_extract();
    tick(0, 0, 1, 0, 33, 70);
    chk("R5 load before hit", 32'(load), 32'd1);
    tick(1, 0, 0, 0, 0, 0);
    chk("R2 after load gain", 32'(slow_gain), 32'd1);
    chk("R2 after load res",  32'(res_low),   32'd0);
    idle();

    // mixed random traffic, checked by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      tick(($urandom_range(0, 39) == 0), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 5) == 0), ($urandom_range(0, 2) == 0),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 4095)));
    end
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule